// File: doc/BRIEF.md
# Multi-Port Half-Word Register File

This block is a synchronous register file of 34 words of 64 bits. It has six write ports and ten read ports, and all of them work independently. Each port has a 4-bit control field. The field turns the port on and chooses the part of the word it touches: the lower 32 bits, the upper 32 bits, or the whole word. Each port also has a 6-bit word address.

Within one clock cycle, all writes are merged into the stored state before any read of that cycle is served. A read therefore returns data written in the same cycle, including a word put together from half-word writes by several ports. Read data is registered and appears one clock after the read port is sampled. A retention input stops all port activity and keeps the stored words unchanged until it is released.

Top module: `mprf_top`

## Requirements
- R1: The storage holds 34 words of 64 bits. Six write ports and ten read ports may all be used in the same cycle, each with its own address.
- R2: The control field encoding is: bit 0 enables the port, bit 1 selects bits 31:0, and bit 2 selects bits 63:32. Bit 3 has no effect. A port that is not enabled, or that is enabled with neither half selected, makes no access.
- R3: A write of one half leaves the other half of the stored word unchanged.
- R4: A read of one half returns zero in the half that was not selected. A read port that makes no access returns all zeros.
- R5: Read data appears on the output one clock edge after the read address and control are sampled, and holds until the next edge.
- R6: A read returns the state after all of that cycle's writes have been applied. This includes a word merged from half-word writes by different ports.
- R7: When two or more enabled write ports write the same half of the same word in one cycle, the port with the highest index wins.
- R8: A write to an address of 34 or above changes no stored word.
- R9: A read from an address of 34 or above returns all zeros.
- R10: While retain is high, writes are blocked and every read output is zero. The stored words are unchanged when retain goes low.
- R11: An active-low reset clears every stored word and every read output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retain | input | 1 | Retention mode: blocks writes and zeroes read outputs |
| wrCtl | input | 24 | Write port controls, 4 bits per port, port p at [4p+3:4p] |
| wrAddr | input | 36 | Write word addresses, 6 bits per port |
| wrData | input | 384 | Write data, 64 bits per port |
| rdCtl | input | 40 | Read port controls, 4 bits per port |
| rdAddr | input | 60 | Read word addresses, 6 bits per port |
| rdData | output | 640 | Registered read data, 64 bits per port |

## Verification
Every read result, including write-through, half-word and out-of-range results, is due exactly one clock edge after its port is sampled. Stored state changed by a write is visible on the read that follows that same edge. Inputs are driven on the falling edge, and the driver computes the expected value of each read port from a bench model that applies all writes first. The monitor compares these values 2 ns after the next rising edge. Each expectation is therefore checked in the single cycle where it is due, and never earlier or later.

// File: rtl/mprf_pkg.sv
package mprf_pkg;
  localparam int NUM_WR = 6;
  localparam int NUM_RD = 10;
  localparam int DEPTH  = 34;
  localparam int WIDTH  = 64;
  localparam int HALF   = WIDTH / 2;
  localparam int AW     = 6;
  localparam int CTL_W  = 4;

  localparam int CTL_EN = 0;
  localparam int CTL_LO = 1;
  localparam int CTL_HI = 2;

  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  typedef struct packed {
    logic [NUM_WR-1:0] wLo;
    logic [NUM_WR-1:0] wHi;
    logic [NUM_RD-1:0] rLo;
    logic [NUM_RD-1:0] rHi;
  } strobe_t;
endpackage

// File: rtl/mprf_ctrl.sv
module mprf_ctrl
  import mprf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    retain,
  input  logic [NUM_WR*CTL_W-1:0] wrCtl,
  input  logic [NUM_WR*AW-1:0]    wrAddr,
  input  logic [NUM_RD*CTL_W-1:0] rdCtl,
  input  logic [NUM_RD*AW-1:0]    rdAddr,
  output strobe_t                 strb
);
  logic [NUM_WR-1:0] wLo, wHi;
  logic [NUM_RD-1:0] rLo, rHi;
  logic [NUM_WR+NUM_RD-1:0] unusedRsv;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    logic [CTL_W-1:0] c;
    logic inRange;
    assign c        = wrCtl[p*CTL_W +: CTL_W];
    assign inRange  = wrAddr[p*AW +: AW] < LIMIT;
    assign wLo[p]   = !retain && c[CTL_EN] && c[CTL_LO] && inRange;
    assign wHi[p]   = !retain && c[CTL_EN] && c[CTL_HI] && inRange;
    assign unusedRsv[p] = c[CTL_W-1];
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic [CTL_W-1:0] c;
    logic inRange;
    assign c        = rdCtl[r*CTL_W +: CTL_W];
    assign inRange  = rdAddr[r*AW +: AW] < LIMIT;
    assign rLo[r]   = !retain && c[CTL_EN] && c[CTL_LO] && inRange;
    assign rHi[r]   = !retain && c[CTL_EN] && c[CTL_HI] && inRange;
    assign unusedRsv[NUM_WR+r] = c[CTL_W-1];

    AST_RD_STROBE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.rLo[r] || strb.rHi[r]) |-> (!retain && rdAddr[r*AW +: AW] < LIMIT)); // R9
  end

  assign strb = {wLo, wHi, rLo, rHi};

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wchk
    AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.wLo[p] || strb.wHi[p]) |-> wrCtl[p*CTL_W + CTL_EN]); // R2
  end
endmodule

// File: rtl/mprf_data.sv
module mprf_data
  import mprf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strb,
  input  logic [NUM_WR*AW-1:0]    wrAddr,
  input  logic [NUM_WR*WIDTH-1:0] wrData,
  input  logic [NUM_RD*AW-1:0]    rdAddr,
  output logic [NUM_RD*WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem     [DEPTH];
  logic [WIDTH-1:0] nextMem [DEPTH];
  logic [WIDTH-1:0] rdNext  [NUM_RD];
  logic [WIDTH-1:0] rdQ     [NUM_RD];
  logic [DEPTH-1:0] loHit, hiHit;

  // Apply writes in ascending port order so the highest index lands last.
  always_comb begin
    nextMem = mem;
    for (int p = 0; p < NUM_WR; p++) begin
      if (strb.wLo[p])
        nextMem[wrAddr[p*AW +: AW]][HALF-1:0] = wrData[p*WIDTH +: HALF];
      if (strb.wHi[p])
        nextMem[wrAddr[p*AW +: AW]][WIDTH-1:HALF] = wrData[p*WIDTH+HALF +: HALF];
    end
  end

  // Write-through: reads see the merged next state.
  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      rdNext[r] = '0;
      if (strb.rLo[r]) rdNext[r][HALF-1:0]     = nextMem[rdAddr[r*AW +: AW]][HALF-1:0];
      if (strb.rHi[r]) rdNext[r][WIDTH-1:HALF] = nextMem[rdAddr[r*AW +: AW]][WIDTH-1:HALF];
    end
  end

  always_comb begin
    loHit = '0;
    hiHit = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      for (int w = 0; w < DEPTH; w++) begin
        if (strb.wLo[p] && wrAddr[p*AW +: AW] == AW'(w)) loHit[w] = 1'b1;
        if (strb.wHi[p] && wrAddr[p*AW +: AW] == AW'(w)) hiHit[w] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      for (int r = 0; r < NUM_RD; r++) rdQ[r] <= '0;
    end else begin
      mem <= nextMem;
      rdQ <= rdNext;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_out
    assign rdData[r*WIDTH +: WIDTH] = rdQ[r];

    AST_RD_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.rLo[r] |=> rdData[r*WIDTH +: HALF] == '0); // R4
    AST_RD_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.rHi[r] |=> rdData[r*WIDTH+HALF +: HALF] == '0); // R4
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_hold
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !loHit[w] |=> mem[w][HALF-1:0] == $past(mem[w][HALF-1:0])); // R3
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hiHit[w] |=> mem[w][WIDTH-1:HALF] == $past(mem[w][WIDTH-1:HALF])); // R3
  end
endmodule

// File: rtl/mprf_top.sv
module mprf_top
  import mprf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    retain,
  input  logic [NUM_WR*CTL_W-1:0] wrCtl,
  input  logic [NUM_WR*AW-1:0]    wrAddr,
  input  logic [NUM_WR*WIDTH-1:0] wrData,
  input  logic [NUM_RD*CTL_W-1:0] rdCtl,
  input  logic [NUM_RD*AW-1:0]    rdAddr,
  output logic [NUM_RD*WIDTH-1:0] rdData
);
  strobe_t strb;

  mprf_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .retain (retain),
    .wrCtl  (wrCtl),
    .wrAddr (wrAddr),
    .rdCtl  (rdCtl),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  mprf_data u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  AST_RETAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    retain |=> rdData == '0); // R10

  for (genvar r = 0; r < NUM_RD; r++) begin : g_oor
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdAddr[r*AW +: AW] >= LIMIT) |=> rdData[r*WIDTH +: WIDTH] == '0); // R9
  end
endmodule

// File: tb/mprf_top_bench.sv
module mprf_top_bench;
  import mprf_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, retain;
  logic [CTL_W-1:0] wc [NUM_WR];
  logic [AW-1:0]    wa [NUM_WR];
  logic [WIDTH-1:0] wd [NUM_WR];
  logic [CTL_W-1:0] rc [NUM_RD];
  logic [AW-1:0]    ra [NUM_RD];

  logic [NUM_WR*CTL_W-1:0] wrCtl;
  logic [NUM_WR*AW-1:0]    wrAddr;
  logic [NUM_WR*WIDTH-1:0] wrData;
  logic [NUM_RD*CTL_W-1:0] rdCtl;
  logic [NUM_RD*AW-1:0]    rdAddr;
  logic [NUM_RD*WIDTH-1:0] rdData;

  always_comb begin
    for (int p = 0; p < NUM_WR; p++) begin
      wrCtl[p*CTL_W +: CTL_W] = wc[p];
      wrAddr[p*AW +: AW]      = wa[p];
      wrData[p*WIDTH +: WIDTH] = wd[p];
    end
    for (int r = 0; r < NUM_RD; r++) begin
      rdCtl[r*CTL_W +: CTL_W] = rc[r];
      rdAddr[r*AW +: AW]      = ra[r];
    end
  end

  mprf_top u_mprf_top (
    .clk(clk), .rst_n(rst_n), .retain(retain),
    .wrCtl(wrCtl), .wrAddr(wrAddr), .wrData(wrData),
    .rdCtl(rdCtl), .rdAddr(rdAddr), .rdData(rdData)
  );

  int errors = 0;
  int checks = 0;
  logic [WIDTH-1:0] mdl [DEPTH];
  logic [WIDTH-1:0] expQ [$];
  int               portQ [$];
  string            tagQ [$];

  task automatic clearPorts();
    for (int p = 0; p < NUM_WR; p++) begin wc[p] = '0; wa[p] = '0; wd[p] = '0; end
    for (int r = 0; r < NUM_RD; r++) begin rc[r] = '0; ra[r] = '0; end
  endtask

  task automatic setWr(int p, logic [3:0] c, int a, logic [WIDTH-1:0] d);
    wc[p] = c; wa[p] = AW'(a); wd[p] = d;
  endtask

  task automatic setRd(int r, logic [3:0] c, int a);
    rc[r] = c; ra[r] = AW'(a);
  endtask

  // Driver: model all writes first, then push each read port's expectation.
  task automatic step(string tag);
    logic [WIDTH-1:0] e;
    if (!retain) begin
      for (int p = 0; p < NUM_WR; p++) begin
        if (wc[p][0] && int'(wa[p]) < DEPTH) begin
          if (wc[p][1]) mdl[wa[p]][HALF-1:0]     = wd[p][HALF-1:0];
          if (wc[p][2]) mdl[wa[p]][WIDTH-1:HALF] = wd[p][WIDTH-1:HALF];
        end
      end
    end
    for (int r = 0; r < NUM_RD; r++) begin
      e = '0;
      if (!retain && rc[r][0] && int'(ra[r]) < DEPTH) begin
        if (rc[r][1]) e[HALF-1:0]     = mdl[ra[r]][HALF-1:0];
        if (rc[r][2]) e[WIDTH-1:HALF] = mdl[ra[r]][WIDTH-1:HALF];
      end
      expQ.push_back(e); portQ.push_back(r); tagQ.push_back(tag);
    end
    @(negedge clk);
    clearPorts();
  endtask

  // Monitor: results are due just after the next rising edge.
  always @(posedge clk) begin
    int p;
    logic [WIDTH-1:0] e;
    string t;
    #2;
    while (expQ.size() > 0) begin
      p = portQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData[p*WIDTH +: WIDTH] !== e) begin
        errors++;
        $display("FAIL %s read port %0d: actual %h expected %h", t, p, rdData[p*WIDTH +: WIDTH], e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R5: actual hung expected finished run");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retain = 1'b0;
    clearPorts();
    for (int w = 0; w < DEPTH; w++) mdl[w] = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (rdData !== '0) begin
      errors++;
      $display("FAIL R11 reset outputs: actual %h expected 0", rdData[WIDTH-1:0]);
    end
    @(negedge clk); rst_n = 1'b1;

    // R11: every word reads back zero after reset
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < NUM_RD; r++) if (b*NUM_RD + r < DEPTH) setRd(r, 4'b0111, b*NUM_RD + r);
      step("R11");
    end

    // R1: all six write ports at once, then read back
    setWr(0, 4'b0111, 0,  64'h0000_0001_A5A5_0000);
    setWr(1, 4'b0111, 5,  64'h1111_2222_3333_4444);
    setWr(2, 4'b0111, 11, 64'hDEAD_BEEF_0BAD_F00D);
    setWr(3, 4'b0111, 20, 64'hCAFE_F00D_1234_5678);
    setWr(4, 4'b0111, 27, 64'h0F0F_0F0F_F0F0_F0F0);
    setWr(5, 4'b0111, 33, 64'h8000_0000_0000_0001);
    step("R1");
    setRd(0, 4'b0111, 0); setRd(1, 4'b0111, 5); setRd(2, 4'b0111, 11);
    setRd(3, 4'b0111, 20); setRd(4, 4'b0111, 27); setRd(9, 4'b0111, 33);
    setRd(5, 4'b0111, 1);
    step("R1");

    // R5: output follows the address one edge later
    setRd(6, 4'b0111, 0); step("R5");
    setRd(6, 4'b0111, 5); step("R5");
    step("R5");

    // R6: write-through merging halves from two ports
    setWr(2, 4'b0011, 12, 64'hFFFF_FFFF_AAAA_0001);
    setWr(4, 4'b0101, 12, 64'hBBBB_0002_FFFF_FFFF);
    setRd(3, 4'b0111, 12); setRd(7, 4'b0011, 12);
    step("R6");
    setRd(0, 4'b0111, 12); step("R6");

    // R7: highest index wins on collisions
    setWr(1, 4'b0111, 7, 64'h1);
    setWr(3, 4'b0111, 7, 64'h3);
    setWr(5, 4'b0111, 7, 64'h5555_5555_5555_5555);
    setRd(0, 4'b0111, 7);
    step("R7");
    setWr(1, 4'b0111, 8, 64'h1111_1111_1111_1111);
    setWr(5, 4'b0011, 8, 64'h9999_9999_5555_5555);
    setRd(2, 4'b0111, 8);
    step("R7");

    // R3: half writes keep the other half
    setWr(0, 4'b0011, 5, 64'hFFFF_FFFF_7777_7777); step("R3");
    setWr(3, 4'b0101, 11, 64'h6666_6666_FFFF_FFFF); step("R3");
    setRd(0, 4'b0111, 5); setRd(1, 4'b0111, 11); step("R3");

    // R4: half reads zero the other half, disabled port gives zero
    setRd(0, 4'b0011, 20); setRd(1, 4'b0101, 20); setRd(2, 4'b0110, 20);
    step("R4");

    // R2: reserved bit ignored, enable without halves does nothing
    setWr(0, 4'b1111, 9, 64'h0123_4567_89AB_CDEF);
    setWr(1, 4'b0001, 11, 64'hFFFF_FFFF_FFFF_FFFF);
    setWr(2, 4'b0110, 27, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R2");
    setRd(0, 4'b1011, 9); setRd(1, 4'b0111, 11); setRd(2, 4'b0111, 27);
    setRd(3, 4'b1000, 9); step("R2");

    // R8: out-of-range writes alter nothing
    setWr(0, 4'b0111, 34, '1); setWr(1, 4'b0111, 40, '1);
    setWr(2, 4'b0111, 63, '1); setWr(3, 4'b0111, 50, '1);
    step("R8");
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < NUM_RD; r++) if (b*NUM_RD + r < DEPTH) setRd(r, 4'b0111, b*NUM_RD + r);
      step("R8");
    end

    // R9: out-of-range reads give zero
    setRd(0, 4'b0111, 34); setRd(1, 4'b0111, 35); setRd(2, 4'b0111, 50);
    setRd(3, 4'b0111, 63); setRd(4, 4'b0111, 2);
    step("R9");

    // R10: retention blocks writes, zeroes reads, keeps contents
    retain = 1'b1;
    setWr(0, 4'b0111, 5, 64'hEEEE_EEEE_EEEE_EEEE); setRd(0, 4'b0111, 5); setRd(1, 4'b0111, 0);
    step("R10");
    setRd(2, 4'b0111, 12); step("R10");
    retain = 1'b0;
    setRd(0, 4'b0111, 5); setRd(1, 4'b0111, 0); setRd(2, 4'b0111, 12);
    step("R10");

    // R6: random traffic against the model
    for (int i = 0; i < 400; i++) begin
      retain = ($urandom_range(0, 15) == 0);
      for (int p = 0; p < NUM_WR; p++)
        setWr(p, 4'($urandom_range(0, 15)), $urandom_range(0, 37), {$urandom(), $urandom()});
      for (int r = 0; r < NUM_RD; r++)
        setRd(r, 4'($urandom_range(0, 15)), $urandom_range(0, 37));
      step("R6");
    end
    retain = 1'b0;

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule